// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns eight general-purpose input pins into interrupt requests. Each pin is brought into the clock domain through a synchroniser. It can then pass through an optional debounce filter. After that, the detector for the pin sees the clean value. For each pin, software chooses level or edge sensitivity, the active polarity or transition, whether the pin may interrupt at all, and whether the debounce filter is used.

Edge events are held in a pending latch until software writes a one to that bit of the end-of-interrupt register. Level requests follow the filtered pin directly. The enabled, active requests can be read as a status byte. They are also driven out as eight separate per-line interrupts and as one combined interrupt, which suits both a chained handler and direct per-line routing.

Configuration goes through a byte-wide register bus. Writes take effect on the clock edge where the write strobe is high. Reads are returned combinationally for the address that is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset, every configuration register reads 0x00, all pending latches are clear, and both `irq_line` and `irq_any` are 0.
- R2: A line in level mode (bit 0 in the mode register at 0x00) reports active while its filtered input equals its polarity bit (register 0x04: 1 = high, 0 = low). It drops as soon as the input leaves that level.
- R3: A line in edge mode (bit 1 in register 0x00) latches a pending request on the selected transition of its filtered input (register 0x04: 1 = rising, 0 = falling). The request stays set after the input returns.
- R4: A line whose bit in the enable register (0x0C) is 0 never shows up in status, in `irq_line` or in `irq_any`, whatever its input does.
- R5: Writing the end-of-interrupt register (0x08) clears the pending edge latch of each line written as 1. Lines written as 0 keep their state, and level-mode lines are not affected at all.
- R6: If an edge event and an end-of-interrupt clear for the same line fall on the same clock edge, the line ends up pending.
- R7: With its bit set in the debounce register (0x18), a line's filtered value changes only after the synchronised input has differed from it on 4 consecutive prescaler ticks. A shorter glitch is never seen.
- R8: The status register at 0x14 is read-only, and writes to it have no effect. The end-of-interrupt register reads back as 0x00. The mode, polarity, enable and debounce registers read back what was last written.
- R9: `irq_line` equals the status byte, and `irq_any` is the OR of its bits.
- R10: With debounce off, a pin change is visible at the detector after exactly three clock edges: two synchroniser stages and the filter register. A level-mode status therefore changes on the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous input pins |
| irq_line | output | 8 | Per-line interrupt requests |
| irq_any | output | 1 | OR of all per-line requests |

## Verification
The assertions check on every cycle that a disabled line stays silent and that a latched edge request is held until it is cleared. They also check that a clear never defeats an edge arriving in the same cycle, and that a debounced line only moves its filtered value on a prescaler tick. The bench scenarios are needed to show the exact three-edge latency, the choice of polarity and transition, glitch rejection against a sustained change, the per-bit selectivity of the end-of-interrupt write, and the register read-back map.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int LINES  = 8;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE   = 5'h00,
        ADR_POL    = 5'h04,
        ADR_CLEAR  = 5'h08,
        ADR_ENABLE = 5'h0C,
        ADR_STATUS = 5'h14,
        ADR_FILTER = 5'h18
    } reg_addr_e;

    typedef struct packed {
        logic [LINES-1:0] edge_sel;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] en;
        logic [LINES-1:0] deb;
    } port_cfg_t;

    function automatic logic is_write(input logic wr, input logic [ADDR_W-1:0] a,
                                      input reg_addr_e target);
        return wr && (a == target);
    endfunction

endpackage

// File: rtl/gpio_irq_tick.sv
module gpio_irq_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (cnt == CW'(DIV - 1))  cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic tick,
    input  logic deb_en,
    output logic filt
);
    localparam int CNT_W = $clog2(STABLE + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            filt    <= 1'b0;
            run_cnt <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            if (!deb_en) begin
                filt    <= synced;
                run_cnt <= '0;
            end else if (synced == filt) begin
                run_cnt <= '0;
            end else if (tick) begin
                if (run_cnt == CNT_W'(STABLE - 1)) begin
                    filt    <= synced;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

    // R7: a debounced line only changes value on a prescaler tick
    p_filter_tick_only_r7: assert property (@(posedge clk) disable iff (rst)
        (deb_en && !tick) |=> $stable(filt));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
    input  logic clk,
    input  logic rst,
    input  logic filt,
    input  logic en,
    input  logic edge_sel,
    input  logic pol,
    input  logic clr,
    output logic status
);
    logic filt_q;
    logic pend;
    logic evt;

    assign evt = (filt != filt_q) && (filt == pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            filt_q <= filt;
            if (!en || !edge_sel) pend <= 1'b0;
            else if (evt)         pend <= 1'b1;
            else if (clr)         pend <= 1'b0;
        end
    end

    assign status = en && (edge_sel ? pend : (filt == pol));

    // R4: a disabled line never reports
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !en |-> !status);
    // R3: a pending edge stays until cleared
    p_pend_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (pend && en && edge_sel && !clr) |=> (pend || !en || !edge_sel));
    // R6: set beats a simultaneous clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (evt && clr && en && edge_sel) |=> pend);
    // R5: a clear with no new event drops the latch
    p_clear_works_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt && edge_sel) |=> !pend);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PRESCALE    = 4,
    parameter int STABLE      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rd_data,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  irq_line,
    output logic              irq_any
);
    port_cfg_t        cfg;
    logic [LINES-1:0] clr_vec;
    logic [LINES-1:0] filt_vec;
    logic [LINES-1:0] status;
    logic             tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (is_write(bus_wr, bus_addr, ADR_MODE))   cfg.edge_sel <= bus_wdata;
            if (is_write(bus_wr, bus_addr, ADR_POL))    cfg.pol      <= bus_wdata;
            if (is_write(bus_wr, bus_addr, ADR_ENABLE)) cfg.en       <= bus_wdata;
            if (is_write(bus_wr, bus_addr, ADR_FILTER)) cfg.deb      <= bus_wdata;
        end
    end

    assign clr_vec = is_write(bus_wr, bus_addr, ADR_CLEAR) ? bus_wdata : '0;

    gpio_irq_tick #(.DIV(PRESCALE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_irq_filter #(.SYNC_STAGES(SYNC_STAGES), .STABLE(STABLE)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .pin    (pin_in[i]),
            .tick   (tick),
            .deb_en (cfg.deb[i]),
            .filt   (filt_vec[i])
        );
        gpio_irq_detect u_det (
            .clk      (clk),
            .rst      (rst),
            .filt     (filt_vec[i]),
            .en       (cfg.en[i]),
            .edge_sel (cfg.edge_sel[i]),
            .pol      (cfg.pol[i]),
            .clr      (clr_vec[i]),
            .status   (status[i])
        );
    end

    always_comb begin
        case (bus_addr)
            ADR_MODE:   bus_rd_data = cfg.edge_sel;
            ADR_POL:    bus_rd_data = cfg.pol;
            ADR_ENABLE: bus_rd_data = cfg.en;
            ADR_FILTER: bus_rd_data = cfg.deb;
            ADR_STATUS: bus_rd_data = status;
            default:    bus_rd_data = '0;
        endcase
    end

    assign irq_line = status;
    assign irq_any  = |status;

    // R9: the combined output rises only with some line active
    p_any_needs_line_r9: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> (irq_line != '0));
    // R8: configuration holds without a write
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(cfg));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    import gpio_irq_pkg::*;

    typedef struct {
        bit        is_read;
        logic [7:0] exp;
        string     tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] irq_line;
    logic       irq_any;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    item_t q[$];

    always #10 clk = ~clk;

    gpio_irq_port #(.PRESCALE(2), .STABLE(4), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd_data(bus_rd_data), .pin_in(pin_in),
        .irq_line(irq_line), .irq_any(irq_any)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.is_read) begin
                    if (bus_rd_data !== it.exp) begin
                        errors++;
                        $display("FAIL %s: read actual=%02h expected=%02h", it.tag, bus_rd_data, it.exp);
                    end
                end else if ({irq_any, irq_line} !== {|it.exp, it.exp}) begin
                    errors++;
                    $display("FAIL %s: any/lines actual=%b/%02h expected=%b/%02h",
                             it.tag, irq_any, irq_line, |it.exp, it.exp);
                end
            end
        end
    end

    task automatic expect_lines(input logic [7:0] exp, input string tag);
        item_t it;
        it.is_read = 1'b0; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_read(input reg_addr_e a, input logic [7:0] exp, input string tag);
        item_t it;
        bus_addr = a;
        it.is_read = 1'b1; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input reg_addr_e a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        expect_lines(8'h00, "R1 outputs after reset");
        expect_read(ADR_MODE,   8'h00, "R1 mode reg");
        expect_read(ADR_POL,    8'h00, "R1 pol reg");
        expect_read(ADR_ENABLE, 8'h00, "R1 enable reg");
        expect_read(ADR_FILTER, 8'h00, "R1 filter reg");
        expect_read(ADR_STATUS, 8'h00, "R1 status reg");

        // R10 / R2 level-high latency on line 0
        wr(ADR_POL, 8'h01);
        wr(ADR_ENABLE, 8'h01);
        pin_in[0] = 1'b1;
        idle(2);
        expect_lines(8'h00, "R10 not yet after two edges");
        expect_lines(8'h01, "R10 visible on third edge");
        pin_in[0] = 1'b0;
        idle(4);
        expect_lines(8'h00, "R2 level high drops");
        wr(ADR_POL, 8'h00);
        idle(1);
        expect_lines(8'h01, "R2 level low active");
        expect_read(ADR_STATUS, 8'h01, "R8 status read");
        wr(ADR_CLEAR, 8'h01);
        expect_lines(8'h01, "R5 level unaffected by clear");

        // R3 edges: line1 rising, line3 falling
        wr(ADR_MODE, 8'h0A);
        wr(ADR_POL, 8'h02);
        wr(ADR_ENABLE, 8'h0B);
        pin_in[1] = 1'b1; pin_in[3] = 1'b1;
        idle(6);
        expect_lines(8'h03, "R3 rising latched, falling waits");
        pin_in[1] = 1'b0; pin_in[3] = 1'b0;
        idle(6);
        expect_lines(8'h0B, "R3 rising held, falling latched");
        wr(ADR_CLEAR, 8'h08);
        expect_lines(8'h03, "R5 per-bit clear of line3 only");
        wr(ADR_CLEAR, 8'h02);
        expect_lines(8'h01, "R5 clear line1");

        // R4 disabled line
        wr(ADR_POL, 8'h12);
        pin_in[4] = 1'b1;
        idle(6);
        expect_lines(8'h01, "R4 disabled line silent");
        expect_read(ADR_STATUS, 8'h01, "R4 status excludes disabled");
        pin_in[4] = 1'b0;
        wr(ADR_POL, 8'h02);
        idle(4);

        // R6 set wins over same-edge clear on line1
        pin_in[1] = 1'b1;
        idle(3);
        wr(ADR_CLEAR, 8'h02);
        expect_lines(8'h03, "R6 set wins over clear");
        wr(ADR_CLEAR, 8'h02);
        expect_lines(8'h01, "R6 later clear works");

        // R7 debounce on line2, level high
        wr(ADR_POL, 8'h06);
        wr(ADR_FILTER, 8'h04);
        wr(ADR_ENABLE, 8'h0F);
        idle(4);
        expect_lines(8'h01, "R7 idle before glitch");
        pin_in[2] = 1'b1;
        idle(3);
        pin_in[2] = 1'b0;
        idle(20);
        expect_lines(8'h01, "R7 short glitch rejected");
        pin_in[2] = 1'b1;
        idle(30);
        expect_lines(8'h05, "R7 sustained level passes");

        // R8 register map
        expect_read(ADR_CLEAR,  8'h00, "R8 clear reads zero");
        expect_read(ADR_MODE,   8'h0A, "R8 mode readback");
        expect_read(ADR_FILTER, 8'h04, "R8 filter readback");
        wr(ADR_STATUS, 8'hFF);
        expect_read(ADR_STATUS, 8'h05, "R8 status write ignored");
        expect_lines(8'h05, "R9 outputs match status");

        idle(2);
        finish_run();
    end
endmodule